// File: doc/BRIEF.md
# Receive Interrupt Moderation Timers

This block decides when a network receive path should interrupt the host. Each time a packet finishes moving into host memory, the DMA side sends a one-cycle completion pulse and the packet's length. The block runs two countdown timers from those completions. The absolute timer bounds the total wait from the first packet of a burst. The packet delay timer fires after a quiet gap with no further completions. When either timer runs out, the block raises one receive interrupt and both timers go idle.

Beside the timers, a small-packet detector compares the length of each completed packet with a programmed threshold. It can raise an interrupt immediately without disturbing the timers. The compared length counts the CRC and the VLAN tag unless the packet arrives with them already removed. Both timers count down on a shared tick made by a programmable prescaler from the core clock. Each interrupt pulse carries cause bits that tell a timer expiry apart from a small-packet hit.

Top module: `rx_irq_moderator`

## Requirements
- R1: `irq` is a one-cycle pulse. It is high in a cycle exactly when `cause_timer` or `cause_small` is high, and all three are low after reset.
- R2: A completion seen while both timers are idle loads the absolute timer with `abs_limit` and the packet delay timer with `gap_limit`. With `tick_div` = 0, a timer loaded with value L expires on the L-th clock edge after the completion edge, and `irq` rises with `cause_timer` = 1.
- R3: Every completion reloads the packet delay timer with `gap_limit`, so the expiry is counted from the last completion.
- R4: After an expiry both timers are idle, and no further timer interrupt occurs until another completion arrives.
- R5: While the absolute timer runs, later completions do not reload it, so it expires on its original schedule even when packets keep arriving.
- R6: A timer whose limit is 0 is disabled and never expires.
- R7: When `small_size` is 0, small-packet detection is off and no completion sets `cause_small`.
- R8: When detection is on, a completion whose effective length is at most `small_size` raises `irq` with `cause_small` = 1 on the same clock edge that samples the completion.
- R9: The effective length is `pkt_len` minus 4 when `crc_stripped` is set, minus a further 4 when `vlan_stripped` is set, and never goes below 0.
- R10: A small-packet hit neither clears nor restarts the timers, so one packet can produce a small-packet interrupt and a later timer interrupt.
- R11: When a timer expiry and a small-packet hit fall in the same cycle, a single pulse is raised with both cause bits set.
- R12: The timers advance once every `tick_div`+1 clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_done | input | 1 | One-cycle pulse: a packet finished transferring to host memory |
| pkt_len | input | LW | Length of that packet, headers and CRC included |
| crc_stripped | input | 1 | The CRC was removed before the transfer |
| vlan_stripped | input | 1 | A VLAN tag was removed before the transfer |
| tick_div | input | PW | Clock cycles per timer tick, minus one |
| abs_limit | input | TW | Absolute timer load value in ticks, 0 disables it |
| gap_limit | input | TW | Packet delay timer load value in ticks, 0 disables it |
| small_size | input | LW | Small-packet threshold, 0 disables detection |
| irq | output | 1 | Receive interrupt pulse |
| cause_timer | output | 1 | The pulse comes from a timer expiry |
| cause_small | output | 1 | The pulse comes from a small-packet hit |

## Verification
A small-packet result appears on the edge that samples the completion. With a tick on every clock, a timer result appears exactly L edges after the completion edge. The bench keeps a running edge count, notes the edge of each completion and logs the edge of every pulse at the falling clock. It then compares the logged edge with the expected one exactly, and checks that no pulse occurs in the edges before it. When the prescaler is slower, the tick phase is not fixed, so the check accepts any edge between (L-1)·(div+1)+1 and L·(div+1) after the completion.

// File: rtl/rx_irq_moderator.sv
module rx_irq_moderator #(
  parameter int TW = 16,
  parameter int LW = 14,
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pkt_done,
  input  logic [LW-1:0] pkt_len,
  input  logic          crc_stripped,
  input  logic          vlan_stripped,
  input  logic [PW-1:0] tick_div,
  input  logic [TW-1:0] abs_limit,
  input  logic [TW-1:0] gap_limit,
  input  logic [LW-1:0] small_size,
  output logic          irq,
  output logic          cause_timer,
  output logic          cause_small
);
  localparam logic [LW:0] TAG = (LW+1)'(4);
  localparam logic [TW-1:0] ONE = TW'(1);

  logic [PW-1:0] presc;
  logic [TW-1:0] abs_cnt, gap_cnt;
  logic          abs_run, gap_run;
  logic          tick, expire, idle, start, small_hit;
  logic [LW:0]   strip_len, raw_len, eff_len;

  assign tick = (presc == tick_div);
  assign expire = tick && ((abs_run && abs_cnt == ONE) || (gap_run && gap_cnt == ONE));
  assign idle = expire || !(abs_run || gap_run);
  assign start = pkt_done && idle;

  assign raw_len = {1'b0, pkt_len};
  assign strip_len = (crc_stripped ? TAG : '0) + (vlan_stripped ? TAG : '0);
  assign eff_len = (raw_len > strip_len) ? raw_len - strip_len : '0;
  assign small_hit = pkt_done && (small_size != '0) && (eff_len <= {1'b0, small_size});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      presc <= '0;
      abs_cnt <= '0;
      gap_cnt <= '0;
      abs_run <= 1'b0;
      gap_run <= 1'b0;
      irq <= 1'b0;
      cause_timer <= 1'b0;
      cause_small <= 1'b0;
    end else begin
      presc <= tick ? '0 : presc + 1'b1;
      irq <= expire || small_hit;
      cause_timer <= expire;
      cause_small <= small_hit;

      if (start) begin
        abs_run <= (abs_limit != '0);
        abs_cnt <= abs_limit;
      end else if (expire) begin
        abs_run <= 1'b0;
      end else if (tick && abs_run) begin
        abs_cnt <= abs_cnt - ONE;
      end

      if (pkt_done) begin
        gap_run <= (gap_limit != '0);
        gap_cnt <= gap_limit;
      end else if (expire) begin
        gap_run <= 1'b0;
      end else if (tick && gap_run) begin
        gap_cnt <= gap_cnt - ONE;
      end
    end
  end
endmodule

module rx_irq_moderator_chk #(
  parameter int TW = 16,
  parameter int LW = 14
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pkt_done,
  input logic [LW-1:0] small_size,
  input logic          abs_run,
  input logic          gap_run,
  input logic          irq,
  input logic          cause_timer,
  input logic          cause_small
);
  // R1
  irq_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (cause_timer || cause_small));
  // R1
  cause_has_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cause_timer || cause_small) |-> irq);
  // R8
  small_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cause_small) |-> $past(pkt_done));
  // R7
  small_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cause_small) |-> ($past(small_size) != '0));
  // R2
  timer_was_running_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cause_timer) |-> $past(abs_run || gap_run));
endmodule

bind rx_irq_moderator rx_irq_moderator_chk #(.TW(TW), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .pkt_done(pkt_done), .small_size(small_size),
  .abs_run(abs_run), .gap_run(gap_run), .irq(irq),
  .cause_timer(cause_timer), .cause_small(cause_small)
);

// File: tb/sim_rx_irq_moderator.sv
module sim_rx_irq_moderator;
  localparam int CLK_PERIOD = 10;
  localparam int TW = 16, LW = 14, PW = 8;

  logic clk = 0, rst_n = 0, pkt_done = 0, crc_stripped = 0, vlan_stripped = 0;
  logic [LW-1:0] pkt_len = '0, small_size = '0;
  logic [PW-1:0] tick_div = '0;
  logic [TW-1:0] abs_limit = '0, gap_limit = '0;
  logic irq, cause_timer, cause_small;

  int tests = 0, fails = 0, cyc = 0, irq_cnt = 0, last_cyc = -1;
  logic last_ct = 0, last_cs = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_irq_moderator #(.TW(TW), .LW(LW), .PW(PW)) u0 (
    .clk(clk), .rst_n(rst_n), .pkt_done(pkt_done), .pkt_len(pkt_len),
    .crc_stripped(crc_stripped), .vlan_stripped(vlan_stripped),
    .tick_div(tick_div), .abs_limit(abs_limit), .gap_limit(gap_limit),
    .small_size(small_size), .irq(irq), .cause_timer(cause_timer),
    .cause_small(cause_small));

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk)
    if (rst_n && irq) begin
      irq_cnt++; last_cyc = cyc; last_ct = cause_timer; last_cs = cause_small;
    end

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 0; pkt_done = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    irq_cnt = 0; last_cyc = -1; last_ct = 0; last_cs = 0;
  endtask

  task automatic send(input int len, input bit crc, input bit vlan, output int e);
    pkt_done = 1; pkt_len = LW'(len); crc_stripped = crc; vlan_stripped = vlan;
    @(posedge clk);
    @(negedge clk);
    pkt_done = 0; crc_stripped = 0; vlan_stripped = 0;
    e = cyc;
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 reset irq", int'(irq), 0);
    check("R1 reset causes", int'(cause_timer) + int'(cause_small), 0);
  endtask

  task automatic t_gap_expiry();
    int e;
    do_reset(); tick_div = 0; abs_limit = 0; gap_limit = 5; small_size = 0;
    send(500, 0, 0, e);
    wait_until(e + 4);
    check("R2 no early irq", irq_cnt, 0);
    wait_until(e + 6);
    check("R2 expiry edge", last_cyc - e, 5);
    check("R2 timer cause", int'(last_ct), 1);
    check("R1 single pulse", irq_cnt, 1);
    wait_until(e + 40);
    check("R4 idle after expiry", irq_cnt, 1);
  endtask

  task automatic t_gap_restart();
    int e1, e2;
    do_reset(); tick_div = 0; abs_limit = 0; gap_limit = 6; small_size = 0;
    send(500, 0, 0, e1);
    wait_until(e1 + 3);
    send(500, 0, 0, e2);
    wait_until(e2 + 5);
    check("R3 no irq before reload expiry", irq_cnt, 0);
    wait_until(e2 + 7);
    check("R3 expiry from last completion", last_cyc - e2, 6);
  endtask

  task automatic t_abs_fixed();
    int e, x;
    do_reset(); tick_div = 0; abs_limit = 10; gap_limit = 4; small_size = 0;
    send(500, 0, 0, e);
    for (int k = 1; k <= 3; k++) begin
      wait_until(e + 3*k - 1);
      send(500, 0, 0, x);
    end
    wait_until(e + 11);
    check("R5 absolute expiry edge", last_cyc - e, 10);
    check("R5 timer cause", int'(last_ct), 1);
    wait_until(e + 40);
    check("R4 gap timer stays off", irq_cnt, 1);
  endtask

  task automatic t_zero_limits();
    int e;
    do_reset(); tick_div = 0; abs_limit = 0; gap_limit = 0; small_size = 0;
    send(500, 0, 0, e);
    wait_until(e + 80);
    check("R6 disabled timers", irq_cnt, 0);
  endtask

  task automatic t_small();
    int e;
    do_reset(); tick_div = 0; abs_limit = 0; gap_limit = 0; small_size = 64;
    send(64, 0, 0, e);
    wait_until(e + 1);
    check("R8 small hit count", irq_cnt, 1);
    check("R8 small hit edge", last_cyc - e, 0);
    check("R8 small cause", int'(last_cs), 1);
    check("R8 no timer cause", int'(last_ct), 0);
    send(65, 0, 0, e); wait_until(e + 2);
    check("R8 above size", irq_cnt, 1);
    send(68, 1, 0, e); wait_until(e + 2);
    check("R9 crc stripped", irq_cnt, 2);
    send(72, 1, 1, e); wait_until(e + 2);
    check("R9 both stripped", irq_cnt, 3);
    send(72, 0, 1, e); wait_until(e + 2);
    check("R9 vlan only", irq_cnt, 3);
    send(3, 1, 1, e); wait_until(e + 2);
    check("R9 floor at zero", irq_cnt, 4);
    small_size = 0;
    send(10, 0, 0, e); wait_until(e + 2);
    check("R7 detection off", irq_cnt, 4);
  endtask

  task automatic t_small_keeps_timers();
    int e;
    do_reset(); tick_div = 0; abs_limit = 0; gap_limit = 5; small_size = 64;
    send(40, 0, 0, e);
    wait_until(e + 6);
    check("R10 two interrupts", irq_cnt, 2);
    check("R10 timer edge", last_cyc - e, 5);
    check("R10 timer cause", int'(last_ct), 1);
  endtask

  task automatic t_coincide();
    int e1, e2;
    do_reset(); tick_div = 0; abs_limit = 0; gap_limit = 4; small_size = 64;
    send(500, 0, 0, e1);
    wait_until(e1 + 3);
    send(20, 0, 0, e2);
    wait_until(e2 + 1);
    check("R11 single pulse", irq_cnt, 1);
    check("R11 both causes", int'(last_ct) + int'(last_cs), 2);
    check("R11 edge", e2 - e1, 4);
  endtask

  task automatic t_prescale();
    int e, d;
    do_reset(); tick_div = 3; abs_limit = 0; gap_limit = 3; small_size = 0;
    send(500, 0, 0, e);
    wait_until(e + 20);
    d = last_cyc - e;
    check("R12 one expiry", irq_cnt, 1);
    check("R12 tick spacing", int'(d >= 9 && d <= 12), 1);
  endtask

  initial begin
    t_reset();
    t_gap_expiry();
    t_gap_restart();
    t_abs_fixed();
    t_zero_limits();
    t_small();
    t_small_keeps_timers();
    t_coincide();
    t_prescale();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule